// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block is the transmit side of a serial line coder. An upstream parallel-to-serial stage hands it one data bit per bit period over a ready/valid handshake. The block drives one line output using one of seven codings, chosen at run time. The seven codings are plain level coding, two transition-based level codings, two bi-phase codings that always change at each bit edge, and two split-phase codings. The timebase is `half_tick`, a one-clock enable that pulses twice per bit period. Line changes land on these pulses, either at the start of a bit or at its middle.

Transmission is gated by a request/clear-to-send pair. Raising `rts_req` asks for the line. The first data bit is then accepted only after a start delay. The delay is two bit times if `cts_in` is already high at the request. If clear-to-send arrives later, the delay counts from that moment and is two or three bit times, as chosen by `cts_opt`. When no bit is offered at a bit boundary, the frame ends and the line returns to its idle-high level. The coding mode is captured only while the block is idle, so a frame is always sent in a single coding.

Top module: `sline_enc`

## Requirements
- R1: `mode_sel` codes are: 0 NRZ, 1 NRZI-mark, 2 NRZI-space, 3 FM0, 4 FM1, 5 Manchester, 6 differential Manchester, and 7 is treated as NRZ. In NRZ, the line equals the data bit for both halves of the bit.
- R2: In NRZI-mark, a 1 inverts the line at the start of the bit and a 0 keeps it. NRZI-space is the reverse: a 0 inverts and a 1 keeps. In both, the line holds through the middle of the bit.
- R3: FM0 and FM1 invert the line at the start of every bit. FM0 inverts it again at mid-bit for a 0, and FM1 does so for a 1.
- R4: Manchester sends a 1 as high then low and a 0 as low then high.
- R5: Differential Manchester always inverts the line at mid-bit and also inverts it at the start of the bit for a 0 only.
- R6: `line_out` is high after reset and while idle. When no bit is valid at a bit boundary, the frame ends and the line is high from the next clock on.
- R7: `mode_sel` is captured only while idle. Changing it during a frame has no effect on that frame.
- R8: If `cts_in` is high in the cycle that `rts_req` is first seen while idle, `bit_ready` first pulses on the 4th `half_tick` after that cycle (2 bit times).
- R9: If `cts_in` is low at the request, counting starts from the cycle `cts_in` is first seen high. `bit_ready` first pulses on the 6th `half_tick` after that cycle when `cts_opt`=0 (3 bit times), and on the 4th when `cts_opt`=1.
- R10: `bit_ready` is high only in `half_tick` cycles, once per bit period (every second `half_tick`) during a frame. A bit is transferred when `bit_ready` and `bit_valid` are both high, and the line changes only on the clock after a `half_tick`.
- R11: If `rts_req` falls while the block is still waiting for `cts_in`, the request is cancelled. A later rise of `cts_in` alone starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Enable at twice the bit rate |
| mode_sel | input | 3 | Line coding select (R1 codes) |
| cts_opt | input | 1 | Late clear-to-send delay: 0 = three bit times, 1 = two |
| rts_req | input | 1 | Request to send |
| cts_in | input | 1 | Clear to send |
| bit_valid | input | 1 | Upstream bit valid |
| bit_data | input | 1 | Upstream data bit |
| bit_ready | output | 1 | Block takes the bit this cycle |
| line_out | output | 1 | Coded serial line |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a frame that must have no effect. The bench can only show this by sending a frame whose expected levels are fixed in the original coding, and then switching `mode_sel` right after the first bit is accepted. The late clear-to-send paths also take deliberate staging: the request goes up with `cts_in` low, the block waits for several cycles, and then clear-to-send is raised. A separate run drops the request before `cts_in` rises, which shows that the waiting state is cancelled.

// File: rtl/sle_pkg.sv
package sle_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_NRZ    = 3'd0,
        CODE_NRZI_M = 3'd1,
        CODE_NRZI_S = 3'd2,
        CODE_FM0    = 3'd3,
        CODE_FM1    = 3'd4,
        CODE_MAN    = 3'd5,
        CODE_DMAN   = 3'd6,
        CODE_RSVD   = 3'd7
    } code_e;

    typedef enum logic [1:0] {
        G_IDLE,
        G_WAIT,
        G_HOLD,
        G_SEND
    } gate_e;

    typedef struct packed {
        logic first;
        logic second;
    } halves_t;

    // Levels for both halves of one bit, given the level the line holds now.
    function automatic halves_t encode_bit(code_e c, logic prev, logic b);
        halves_t h;
        case (c)
            CODE_NRZI_M: begin h.first = prev ^ b;    h.second = h.first;    end
            CODE_NRZI_S: begin h.first = prev ^ ~b;   h.second = h.first;    end
            CODE_FM0:    begin h.first = ~prev;       h.second = ~prev ^ ~b; end
            CODE_FM1:    begin h.first = ~prev;       h.second = ~prev ^ b;  end
            CODE_MAN:    begin h.first = b;           h.second = ~b;         end
            CODE_DMAN:   begin h.first = prev ^ ~b;   h.second = ~(prev ^ ~b); end
            default:     begin h.first = b;           h.second = b;          end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/sle_gate.sv
module sle_gate
    import sle_pkg::*;
#(
    parameter int FAST_BITS = 2,
    parameter int SLOW_BITS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic half_tick,
    input  logic rts_req,
    input  logic cts_in,
    input  logic cts_opt,
    input  logic bit_valid,
    output logic bit_ready,
    output logic take_o,
    output logic mid_o,
    output logic idle_o
);
    localparam int LONGEST = (FAST_BITS > SLOW_BITS) ? FAST_BITS : SLOW_BITS;
    localparam int CW      = $clog2(2 * LONGEST + 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(2 * FAST_BITS - 2);
    localparam logic [CW-1:0] SLOW_LIM = CW'(2 * SLOW_BITS - 2);

    gate_e          st;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  lim;
    logic           phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= G_IDLE;
            cnt   <= '0;
            lim   <= '0;
            phase <= 1'b0;
        end else begin
            case (st)
                G_IDLE: begin
                    if (rts_req) begin
                        cnt   <= '0;
                        phase <= 1'b0;
                        if (cts_in) begin
                            st  <= G_HOLD;
                            lim <= FAST_LIM;
                        end else begin
                            st <= G_WAIT;
                        end
                    end
                end
                G_WAIT: begin
                    if (!rts_req) begin
                        st <= G_IDLE;
                    end else if (cts_in) begin
                        st  <= G_HOLD;
                        cnt <= '0;
                        lim <= cts_opt ? FAST_LIM : SLOW_LIM;
                    end
                end
                G_HOLD: begin
                    if (half_tick) begin
                        if (cnt == lim) begin
                            st    <= G_SEND;
                            phase <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (half_tick) begin
                        if (!phase) begin
                            if (bit_valid) phase <= 1'b1;
                            else           st    <= G_IDLE;
                        end else begin
                            phase <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    assign bit_ready = (st == G_SEND) && !phase && half_tick;
    assign take_o    = bit_ready && bit_valid;
    assign mid_o     = (st == G_SEND) && phase && half_tick;
    assign idle_o    = (st == G_IDLE);

    // R8/R9: data phase is reached only through the delay counter
    a_r8_send_after_hold: assert property (@(posedge clk) disable iff (rst)
        (st == G_SEND && $past(st) != G_SEND) |-> $past(st) == G_HOLD);

    // R11: dropping the request while waiting returns to idle
    a_r11_wait_cancel: assert property (@(posedge clk) disable iff (rst)
        (st == G_WAIT && !rts_req) |=> st == G_IDLE);

    // R10: ready never on consecutive cycles
    a_r10_ready_spaced: assert property (@(posedge clk) disable iff (rst)
        bit_ready |=> !bit_ready);

endmodule

// File: rtl/sle_shaper.sv
module sle_shaper
    import sle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_i,
    input  logic              take_i,
    input  logic              mid_i,
    input  logic              bit_i,
    input  logic [CODE_W-1:0] mode_i,
    output logic              line_o
);
    code_e   mode_q;
    logic    line_q;
    logic    second_q;
    halves_t nxt;

    assign nxt = encode_bit(mode_q, line_q, bit_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= CODE_NRZ;
            line_q   <= 1'b1;
            second_q <= 1'b1;
        end else begin
            if (idle_i) begin
                mode_q <= code_e'(mode_i);
                line_q <= 1'b1;
            end
            if (take_i) begin
                line_q   <= nxt.first;
                second_q <= nxt.second;
            end else if (mid_i) begin
                line_q <= second_q;
            end
        end
    end

    assign line_o = line_q;

    // R7: coding only changes from the idle state
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(idle_i));

    // R10: line moves only after a bit start, a mid-bit tick or idle
    a_r10_line_timing: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_q) |-> ($past(take_i) || $past(mid_i) || $past(idle_i)));

    // R3: bi-phase codings always flip at a bit start
    a_r3_fm_edge: assert property (@(posedge clk) disable iff (rst)
        (take_i && (mode_q == CODE_FM0 || mode_q == CODE_FM1)) |=> line_q != $past(line_q));

    // R4, R5: split-phase codings always flip mid-bit
    a_r4_mid_flip: assert property (@(posedge clk) disable iff (rst)
        (mid_i && (mode_q == CODE_MAN || mode_q == CODE_DMAN)) |=> line_q != $past(line_q));

    // R6: line rests high while idle
    a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
        (idle_i && $past(idle_i)) |-> line_q);

endmodule

// File: rtl/sline_enc.sv
module sline_enc
    import sle_pkg::*;
#(
    parameter int FAST_BITS = 2,
    parameter int SLOW_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic [CODE_W-1:0] mode_sel,
    input  logic              cts_opt,
    input  logic              rts_req,
    input  logic              cts_in,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic              bit_ready,
    output logic              line_out
);
    logic take_w;
    logic mid_w;
    logic idle_w;

    sle_gate #(
        .FAST_BITS(FAST_BITS),
        .SLOW_BITS(SLOW_BITS)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .rts_req   (rts_req),
        .cts_in    (cts_in),
        .cts_opt   (cts_opt),
        .bit_valid (bit_valid),
        .bit_ready (bit_ready),
        .take_o    (take_w),
        .mid_o     (mid_w),
        .idle_o    (idle_w)
    );

    sle_shaper u_shaper (
        .clk    (clk),
        .rst    (rst),
        .idle_i (idle_w),
        .take_i (take_w),
        .mid_i  (mid_w),
        .bit_i  (bit_data),
        .mode_i (mode_sel),
        .line_o (line_out)
    );

endmodule

// File: tb/sline_enc_bench.sv
module sline_enc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_tick;
    logic [2:0] mode_sel = 3'd0;
    logic       cts_opt = 1'b0;
    logic       rts_req = 1'b0;
    logic       cts_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready;
    logic       line_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic exp_q[$];
    string cur_req = "R1";
    logic started = 1'b0;
    logic chk_next = 1'b0;
    logic [1:0] div;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            div       <= '0;
            half_tick <= 1'b0;
        end else begin
            div       <= div + 1'b1;
            half_tick <= (div == 2'd3);
        end
    end

    sline_enc u_sline_enc (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .mode_sel  (mode_sel),
        .cts_opt   (cts_opt),
        .rts_req   (rts_req),
        .cts_in    (cts_in),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_ready (bit_ready),
        .line_out  (line_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // reference coding written from transition rules
    task automatic push_bit(int mode, ref logic prev, input logic b);
        logic f, s, t_start, t_mid;
        t_start = 1'b0; t_mid = 1'b0;
        case (mode)
            1: t_start = b;
            2: t_start = !b;
            3: begin t_start = 1'b1; t_mid = !b; end
            4: begin t_start = 1'b1; t_mid = b;  end
            6: begin t_start = !b;   t_mid = 1'b1; end
            default: ;
        endcase
        if (mode == 0 || mode == 7) begin f = b; s = b; end
        else if (mode == 5) begin f = b; s = !b; end
        else begin
            f = t_start ? !prev : prev;
            s = t_mid ? !f : f;
        end
        exp_q.push_back(f);
        exp_q.push_back(s);
        prev = s;
    endtask

    // monitor: compares each half-bit level after the tick that set it
    always @(negedge clk) begin
        if (chk_next && exp_q.size() > 0) begin
            check(cur_req, 32'(line_out), 32'(exp_q.pop_front()));
            if (exp_q.size() == 0) started = 1'b0;
        end
        if (half_tick && bit_ready && bit_valid && !started && exp_q.size() > 0)
            started = 1'b1;
        chk_next = started && half_tick;
        if (bit_ready && !half_tick)
            check("R10", 32'(half_tick), 32'd1);
    end

    task automatic send_frame(int mode, logic pre, logic opt, int n,
                              logic [15:0] bits, int alt, string req);
        logic prev;
        int cnt, gap, exp_delay;
        @(posedge clk); #1;
        mode_sel = 3'(mode);
        cts_opt  = opt;
        cur_req  = req;
        prev = 1'b1;
        for (int i = 0; i < n; i++) push_bit(mode, prev, bits[i]);
        cts_in    = pre;
        rts_req   = 1'b1;
        bit_valid = 1'b1;
        bit_data  = bits[0];
        @(posedge clk);
        if (!pre) begin
            repeat (7) @(posedge clk);
            #1 cts_in = 1'b1;
            @(posedge clk);
        end
        exp_delay = pre ? 4 : (opt ? 4 : 6);
        cnt = 0;
        forever begin
            @(negedge clk);
            if (half_tick) cnt++;
            if (half_tick && bit_ready) break;
        end
        check(pre ? "R8" : "R9", 32'(cnt), 32'(exp_delay));
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                gap = 0;
                forever begin
                    @(negedge clk);
                    if (half_tick) gap++;
                    if (half_tick && bit_ready) break;
                end
                check("R10", 32'(gap), 32'd2);
            end
            @(posedge clk); #1;
            if (i + 1 < n) bit_data = bits[i+1];
            else begin bit_valid = 1'b0; rts_req = 1'b0; cts_in = 1'b0; end
            if (i == 0 && alt >= 0) mode_sel = 3'(alt);
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (12) @(negedge clk);
        check("R6", 32'(line_out), 32'd1);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R6", 32'(line_out), 32'd1);
        check("R10", 32'(bit_ready), 32'd0);
        @(posedge clk); #1 rst = 1'b0;

        send_frame(0, 1'b1, 1'b0, 8, 16'b0000_0000_0100_1101, -1, "R1");
        send_frame(1, 1'b0, 1'b0, 8, 16'b0000_0000_1011_0010, -1, "R2");
        send_frame(2, 1'b0, 1'b1, 8, 16'b0000_0000_1011_0010, -1, "R2");
        send_frame(3, 1'b1, 1'b0, 9, 16'b0000_0001_0011_1001, -1, "R3");
        send_frame(4, 1'b0, 1'b1, 9, 16'b0000_0001_0011_1001, -1, "R3");
        send_frame(5, 1'b1, 1'b0, 8, 16'b0000_0000_0110_1100, 3,  "R7");
        send_frame(5, 1'b0, 1'b0, 6, 16'b0000_0000_0001_0110, -1, "R4");
        send_frame(6, 1'b1, 1'b0, 10, 16'b0000_0011_0010_1101, -1, "R5");
        send_frame(7, 1'b1, 1'b0, 5, 16'b0000_0000_0000_1010, -1, "R1");

        // R11: request withdrawn before clear-to-send arrives
        @(posedge clk); #1;
        rts_req = 1'b1; cts_in = 1'b0; bit_valid = 1'b1;
        repeat (10) @(posedge clk);
        #1 rts_req = 1'b0;
        @(posedge clk); #1 cts_in = 1'b1;
        begin
            logic seen;
            seen = 1'b0;
            repeat (40) begin
                @(negedge clk);
                if (bit_ready) seen = 1'b1;
            end
            check("R11", 32'(seen), 32'd0);
            check("R6", 32'(line_out), 32'd1);
        end
        @(posedge clk); #1 cts_in = 1'b0; bit_valid = 1'b0;
        repeat (4) @(posedge clk);
        finish_up();
    end

endmodule